// File: doc/BRIEF.md
# Dual-Clock Notch Delay Line

This block holds a stream of 8-bit samples in a circular store and plays back two delayed taps of that stream. The difference of the two taps forms a notch filter. Samples arrive on a write-side clock and are stored at the address held by an input counter. Two read pointers run on an independent read-side clock. Each pointer selects one delayed copy of the stream. The block combines the two read values into a 9-bit difference.

Every sample is stored twice, at the same address. One copy is kept bit-inverted, so the difference needs only one adder with a carry-in of one. The first read pointer starts from a programmable preset, which sets the base delay. The second pointer can be reloaded with a new start address while the block runs, which moves the notch on the fly. All pointers share one count direction, up or down, and wrap modulo the store depth. The store depth is 2^ADDR_W; ADDR_W = 13 gives the full 8k store.

Top module: `notch_delay_line`

## Requirements
- R1: While `rst_n` is low at a rising edge of each clock, `wr_addr` clears to 0, `diff_out` clears to 0, the internal read registers clear to 0, and both read pointers load `bucket_preset`.
- R2: At each `wr_clk` edge with `run_en` high, `sample_in` is written into both copies at address `wr_addr`. The copy read by pointer 1 receives the bitwise inverse of the sample.
- R3: `diff_out` equals (inverted copy value at pointer 1) + (true copy value at pointer 2) + 1, taken modulo 512. This equals 256 + s2 − s1, so bit 8 is set exactly when s2 ≥ s1.
- R4: With `run_en` high and `count_down` low, `wr_addr` increases by one per `wr_clk` edge and wraps modulo 2^ADDR_W.
- R5: With `run_en` high, pointer 1 steps once per `rd_clk` edge in the selected direction, starting from the preset loaded in reset.
- R6: At an `rd_clk` edge with `run_en` and `offset_load` both high, pointer 2 takes `offset_value`. From the next edge it steps again from that value.
- R7: With `count_down` high, the write counter and both read pointers decrease by one per enabled edge, wrapping from 0 to 2^ADDR_W − 1.
- R8: Each read value is registered, and the difference is registered too. `diff_out` therefore reflects the pointer values of two `rd_clk` edges earlier.
- R9: While `run_en` is low, all three pointers hold, no sample is written, and `offset_load` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Sample (write-side) clock |
| rd_clk | input | 1 | Playback (read-side) clock, unrelated to wr_clk |
| rst_n | input | 1 | Synchronous active-low reset, sampled by both clocks |
| run_en | input | 1 | Operating mode: pointers advance and samples are written |
| count_down | input | 1 | Pointer direction: 0 counts up, 1 counts down |
| sample_in | input | SAMPLE_W | Incoming sample |
| bucket_preset | input | ADDR_W | Start address of both read pointers after reset |
| offset_load | input | 1 | Load strobe for read pointer 2 (rd_clk domain) |
| offset_value | input | ADDR_W | New start address for read pointer 2 |
| diff_out | output | SAMPLE_W+1 | Registered tap difference |
| wr_addr | output | ADDR_W | Current input address counter value |

## Verification
The bench builds the block with ADDR_W = 6, so each copy holds 64 entries. At that depth, a few hundred samples wrap the write counter and the read pointers many times in both count directions. Overwritten entries then show up at the taps, and pointer 2 reloads can jump across the wrap point. The default 8-bit sample width is kept. Runs of all-zero and all-ones samples drive the carry into bit 8 both ways.

// File: rtl/ndl_pkg.sv
// Shared definitions for the notch delay line.
// Assumes: samples are unsigned bytes; direction is a single static control bit.
package ndl_pkg;

    localparam int unsigned NDL_SAMPLE_W = 8;

    typedef enum logic {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } cnt_dir_e;

endpackage

// File: rtl/ndl_wr_ctrl.sv
// Input address counter and write strobe for the sample store.
// Assumes: rst_n and run_en are synchronous to wr_clk; count_down is quasi-static.
module ndl_wr_ctrl #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              count_down,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_en
);
    import ndl_pkg::*;

    localparam logic [ADDR_W-1:0] STEP_UP = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_DN = '1;

    cnt_dir_e dir;

    // Decode the direction bit into the shared enum.
    always_comb dir = cnt_dir_e'(count_down);

    // A write happens only when running and out of reset.
    always_comb wr_en = rst_n && run_en;

    // Advance the write address once per enabled sample clock.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
        end else if (run_en) begin
            wr_addr <= wr_addr + ((dir == CNT_DOWN) ? STEP_DN : STEP_UP);
        end
    end

    p_wr_up_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (run_en && !count_down) |=> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

    p_wr_down_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (run_en && count_down) |=> (wr_addr == $past(wr_addr) - ADDR_W'(1)));

    p_wr_hold_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !run_en |=> $stable(wr_addr));

endmodule

// File: rtl/ndl_rd_ptrs.sv
// Two read pointers on the playback clock: pointer 1 free-runs from the preset,
// pointer 2 free-runs and may be reloaded while running.
// Assumes: run_en and count_down are stable or synchronized to rd_clk.
module ndl_rd_ptrs #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              count_down,
    input  logic [ADDR_W-1:0] preset,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_value,
    output logic [ADDR_W-1:0] ptr_a,
    output logic [ADDR_W-1:0] ptr_b
);
    import ndl_pkg::*;

    localparam logic [ADDR_W-1:0] STEP_UP = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_DN = '1;

    logic [ADDR_W-1:0] step;

    // Select the signed step from the direction bit.
    always_comb step = (cnt_dir_e'(count_down) == CNT_DOWN) ? STEP_DN : STEP_UP;

    // Preset both pointers in reset; step or reload them while running.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            ptr_a <= preset;
            ptr_b <= preset;
        end else if (run_en) begin
            ptr_a <= ptr_a + step;
            ptr_b <= load ? load_value : ptr_b + step;
        end
    end

    p_ptr_a_step_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (run_en && !count_down) |=> (ptr_a == $past(ptr_a) + ADDR_W'(1)));

    p_ptr_b_load_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (run_en && load) |=> (ptr_b == $past(load_value)));

    p_ptr_hold_r9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !run_en |=> ($stable(ptr_a) && $stable(ptr_b)));

endmodule

// File: rtl/ndl_tap_mem.sv
// Two copies of the sample store sharing one write port. Copy 0 keeps inverted
// data and is read by pointer A; copy 1 keeps true data and is read by pointer B.
// Reads are registered on the playback clock.
// Assumes: the caller avoids reading an address in the same instant it is written.
module ndl_tap_mem #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_inv_a,
    output logic [DATA_W-1:0] rd_true_b
);
    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned COPIES = 2;

    logic [DATA_W-1:0] q_copy [COPIES];

    for (genvar g = 0; g < COPIES; g++) begin : g_copy
        localparam bit INVERT = (g == 0);

        logic [DATA_W-1:0] store [DEPTH];
        logic [ADDR_W-1:0] raddr;

        // Route the pointer that serves this copy.
        always_comb raddr = INVERT ? rd_addr_a : rd_addr_b;

        // Store the sample, inverted for copy 0.
        always_ff @(posedge wr_clk) begin
            if (wr_en) begin
                store[wr_addr] <= INVERT ? ~wr_data : wr_data;
            end
        end

        // Register the read value on the playback clock.
        always_ff @(posedge rd_clk) begin
            if (!rst_n) begin
                q_copy[g] <= '0;
            end else begin
                q_copy[g] <= store[raddr];
            end
        end
    end

    assign rd_inv_a  = q_copy[0];
    assign rd_true_b = q_copy[1];

endmodule

// File: rtl/ndl_diff.sv
// Tap combiner: adds the inverted tap, the true tap and a carry-in of one,
// which gives the difference offset by 2^DATA_W in a DATA_W+1 bit result.
// Assumes: both inputs are registered values from the same clock.
module ndl_diff #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] inv_a,
    input  logic [DATA_W-1:0] true_b,
    output logic [DATA_W:0]   diff
);
    localparam int unsigned OUT_W = DATA_W + 1;

    // Register the sum with carry-in; the carry-out lands in the MSB.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            diff <= '0;
        end else begin
            diff <= OUT_W'(inv_a) + OUT_W'(true_b) + OUT_W'(1);
        end
    end

    p_diff_cleared_r1: assert property (@(posedge rd_clk)
        !rst_n |=> (diff == '0));

endmodule

// File: rtl/notch_delay_line.sv
// Dual-clock notch delay line top: write counter on wr_clk, two read pointers on
// rd_clk, a doubled sample store and a registered tap combiner.
// Assumes: rst_n is held low across at least one edge of each clock; run_en and
// count_down are synchronized by the caller to both domains.
module notch_delay_line #(
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned SAMPLE_W = ndl_pkg::NDL_SAMPLE_W
) (
    input  logic                wr_clk,
    input  logic                rd_clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic                count_down,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [ADDR_W-1:0]   bucket_preset,
    input  logic                offset_load,
    input  logic [ADDR_W-1:0]   offset_value,
    output logic [SAMPLE_W:0]   diff_out,
    output logic [ADDR_W-1:0]   wr_addr
);
    logic                wr_en;
    logic [ADDR_W-1:0]   ptr_a;
    logic [ADDR_W-1:0]   ptr_b;
    logic [SAMPLE_W-1:0] tap_inv;
    logic [SAMPLE_W-1:0] tap_true;

    ndl_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .wr_clk     (wr_clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .count_down (count_down),
        .wr_addr    (wr_addr),
        .wr_en      (wr_en)
    );

    ndl_rd_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
        .rd_clk     (rd_clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .count_down (count_down),
        .preset     (bucket_preset),
        .load       (offset_load),
        .load_value (offset_value),
        .ptr_a      (ptr_a),
        .ptr_b      (ptr_b)
    );

    ndl_tap_mem #(.ADDR_W(ADDR_W), .DATA_W(SAMPLE_W)) u_mem (
        .wr_clk    (wr_clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (sample_in),
        .rd_clk    (rd_clk),
        .rst_n     (rst_n),
        .rd_addr_a (ptr_a),
        .rd_addr_b (ptr_b),
        .rd_inv_a  (tap_inv),
        .rd_true_b (tap_true)
    );

    ndl_diff #(.DATA_W(SAMPLE_W)) u_diff (
        .rd_clk (rd_clk),
        .rst_n  (rst_n),
        .inv_a  (tap_inv),
        .true_b (tap_true),
        .diff   (diff_out)
    );

endmodule

// File: tb/notch_delay_line_test.sv
`timescale 1ns/100ps
// Bench: behavioural reference model of both clock domains, compared on every
// edge of each clock. Edges of the two clocks never coincide.
module notch_delay_line_test;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int MASK  = DEPTH - 1;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic          count_down = 1'b0;
    logic          offset_load = 1'b0;
    logic [7:0]    sample_in = '0;
    logic [AW-1:0] bucket_preset = '0;
    logic [AW-1:0] offset_value = '0;
    logic [8:0]    diff_out;
    logic [AW-1:0] wr_addr;

    notch_delay_line #(.ADDR_W(AW), .SAMPLE_W(8)) uut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .run_en(run_en),
        .count_down(count_down), .sample_in(sample_in),
        .bucket_preset(bucket_preset), .offset_load(offset_load),
        .offset_value(offset_value), .diff_out(diff_out), .wr_addr(wr_addr)
    );

    // 200 MHz write clock: rises at x.5 ns.
    always #2.5 wr_clk = ~wr_clk;
    // 7 ns read clock: rises at 1.3 + 7k ns and falls at 4.8 + 7k ns.
    initial begin
        #1.3;
        forever begin
            rd_clk = 1'b1; #3.5;
            rd_clk = 1'b0; #3.5;
        end
    end

    int    errors = 0;
    int    checks = 0;
    bit    cmp_on = 0;
    bit    finished = 0;
    string rd_tag = "R1";
    string wr_tag = "R1";

    // Reference model state.
    int m_mem [DEPTH];
    bit m_ok  [DEPTH];
    int m_wa, m_p1, m_p2, m_r1i, m_r2, m_diff;
    bit m_vr, m_dv;

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%0d expected=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Write-side model: reset, doubled store, address step.
    always @(posedge wr_clk) begin
        if (!rst_n) begin
            m_wa = 0;
        end else if (run_en) begin
            m_mem[m_wa] = int'(sample_in);
            m_ok[m_wa]  = 1'b1;
            m_wa = (m_wa + (count_down ? -1 : 1)) & MASK;
        end
    end

    // Read-side model: two register stages, then pointer update.
    always @(posedge rd_clk) begin
        if (!rst_n) begin
            m_p1 = int'(bucket_preset); m_p2 = int'(bucket_preset);
            m_r1i = 0; m_r2 = 0; m_vr = 1; m_diff = 0; m_dv = 1;
        end else begin
            m_diff = (m_r2 + m_r1i + 1) & 511;
            m_dv   = m_vr;
            m_r1i  = (~m_mem[m_p1]) & 255;
            m_r2   = m_mem[m_p2];
            m_vr   = m_ok[m_p1] && m_ok[m_p2];
            if (run_en) begin
                m_p1 = (m_p1 + (count_down ? -1 : 1)) & MASK;
                m_p2 = offset_load ? int'(offset_value) : ((m_p2 + (count_down ? -1 : 1)) & MASK);
            end
        end
    end

    // Compare the difference output between read edges.
    always @(negedge rd_clk) begin
        if (cmp_on && m_dv) check(diff_out === 9'(m_diff), rd_tag, int'(diff_out), m_diff);
    end

    // Compare the write address between write edges.
    always @(negedge wr_clk) begin
        if (cmp_on) check(wr_addr === AW'(m_wa), wr_tag, int'(wr_addr), m_wa);
    end

    task automatic drive_wr(input int n, input int mode);
        for (int k = 0; k < n; k++) begin
            @(negedge wr_clk);
            case (mode)
                0:       sample_in = 8'(k * 37 + 11);
                1:       sample_in = k[1] ? 8'hFF : 8'h00;
                default: sample_in = 8'(k * 13 + 7);
            endcase
        end
    endtask

    task automatic pulse_load(input int gap, input int v);
        repeat (gap) @(negedge rd_clk);
        offset_value = AW'(v);
        offset_load  = 1'b1;
        @(negedge rd_clk);
        offset_load  = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #100000;
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        logic [AW-1:0] hold;
        bucket_preset = AW'(40);
        repeat (4) @(negedge wr_clk);
        cmp_on = 1;
        // R1: reset state at the ports.
        @(negedge rd_clk);
        check(wr_addr === '0, "R1 wr_addr in reset", int'(wr_addr), 0);
        check(diff_out === '0, "R1 diff_out in reset", int'(diff_out), 0);

        // Count up, mixed patterns, extremes for the carry, reloads of pointer 2.
        @(negedge wr_clk);
        rd_tag = "R2 R3 R5 R6 R8"; wr_tag = "R4";
        rst_n = 1'b1; run_en = 1'b1;
        fork
            begin drive_wr(120, 0); drive_wr(60, 1); drive_wr(120, 2); end
            begin pulse_load(50, 10); pulse_load(40, 63); pulse_load(40, 0); end
        join

        // R9: disabled, samples change and a reload is attempted.
        @(negedge wr_clk);
        run_en = 1'b0; rd_tag = "R9"; wr_tag = "R9";
        hold = wr_addr;
        fork
            drive_wr(30, 1);
            pulse_load(5, 33);
        join
        @(negedge wr_clk);
        check(wr_addr === hold, "R9 wr_addr held", int'(wr_addr), int'(hold));
        run_en = 1'b1; rd_tag = "R2 R3 R9 after re-enable"; wr_tag = "R4";
        drive_wr(100, 0);

        // R7: count down from a new preset.
        @(negedge wr_clk);
        rst_n = 1'b0; count_down = 1'b1; bucket_preset = AW'(5);
        rd_tag = "R1"; wr_tag = "R1";
        repeat (4) @(negedge wr_clk);
        check(wr_addr === '0, "R1 wr_addr after second reset", int'(wr_addr), 0);
        rst_n = 1'b1; rd_tag = "R7 R3 R6"; wr_tag = "R7";
        fork
            begin drive_wr(150, 2); drive_wr(60, 1); drive_wr(100, 0); end
            begin pulse_load(30, 50); pulse_load(60, 7); pulse_load(50, 62); end
        join
        repeat (4) @(negedge wr_clk);
        summary();
    end

endmodule